// File: doc/BRIEF.md
# DVFS PLL Transition Sequencer

This block moves a clock PLL from one frequency/voltage operating point to another while the PLL keeps running and its voltage-droop detection settings are rewritten. A request carries the old operating point (frequency, post divider, voltage level) and the new one (frequency, reference and feedback dividers, post divider, voltage level, detection coefficient, calibration value, enable) together with a flag that says whether frequency sliding is allowed. The sequencer decides which steps the move needs, issues PLL-programming commands to a downstream unit over a valid/acknowledge handshake, writes the detection coefficient and calibration registers one per cycle, and ends every accepted request with a one-cycle done or error pulse.

When the detection settings must change under a running PLL, the block first drops the PLL to a configuration that is safe with a zero detection coefficient. The coefficient is cleared next, the calibration point is moved to the new voltage, and the new coefficient is written. Only then is the final target programmed. The safe configuration is derived from whichever end point has the lower voltage: the old point when the voltage rises, the new one when it falls. It always runs at the higher of the two voltage levels.

Top module: `dvfs_pll_seq`

## Requirements
- R1: When the new reference divider is not 1, the request ends with an error pulse and issues no command and no register write.
- R2: When sliding is not allowed, the new configuration is disabled, or the old and new voltage levels are equal, the block issues exactly one command: the new configuration with the request's slide flag and enable. It writes no register, then pulses done.
- R3: The safe-frequency command is issued only when the old frequency is strictly above SAFE_MIN_KHZ (614400 kHz by default). At or below that value, the sequence starts directly with the register writes.
- R4: With the voltage rising, the safe command is based on the old frequency and post divider and carries the new voltage level.
- R5: With the voltage falling, the safe command is based on the new frequency and post divider and carries the old voltage level.
- R6: The safe frequency is the base frequency minus SAFE_MARGIN_KHZ when the base exceeds SAFE_MIN_KHZ, else the base unchanged. The safe feedback divider is that frequency divided by REF_KHZ, rounded down. If this divider is below NMIN = ceil(VCO_MIN_KHZ/REF_KHZ), the divider becomes NMIN and the post divider becomes the smallest ratio d with d*freq >= NMIN*REF_KHZ. Otherwise the base post divider is kept. The post divider field is the plain division ratio.
- R7: The safe command always has slide = 1 and enable = 1. If it is acknowledged with failure, the block pulses error and makes no register write and no further command.
- R8: After the safe step, or in its place, exactly three writes occur on consecutive cycles: coefficient = 0, then calibration = new calibration, then coefficient = new coefficient. Select encoding: 0 is the coefficient and 1 is the calibration.
- R9: The sequence ends with the final command (the new configuration, slide = 1). A successful acknowledge is followed by a done pulse, and done and error are never high together.
- R10: A request is accepted only while req_ready is high; req_valid while busy has no effect. Each command's payload stays stable from the cycle cmd_valid rises until the acknowledge.
- R11: A failed acknowledge of the final command ends the request with an error pulse and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Idle, request can be accepted |
| req_slide | input | 1 | Sliding allowed for this move |
| old_freq | input | 22 | Old frequency, kHz |
| old_pdiv | input | 6 | Old post-divider ratio |
| old_mv | input | 11 | Old voltage level, mV |
| new_freq | input | 22 | New frequency, kHz |
| new_mdiv | input | 6 | New reference divider |
| new_ndiv | input | 8 | New feedback divider |
| new_pdiv | input | 6 | New post-divider ratio |
| new_mv | input | 11 | New voltage level, mV |
| new_coef | input | 7 | New detection coefficient |
| new_cal | input | 8 | New calibration value |
| new_en | input | 1 | New configuration enabled |
| cmd_valid | output | 1 | PLL-programming command valid |
| cmd_ack | input | 1 | Command acknowledge |
| cmd_fail | input | 1 | Acknowledged command failed |
| cmd_freq | output | 22 | Command frequency, kHz |
| cmd_ndiv | output | 8 | Command feedback divider |
| cmd_pdiv | output | 6 | Command post-divider ratio |
| cmd_mv | output | 11 | Command voltage level |
| cmd_en | output | 1 | Command enable |
| cmd_slide | output | 1 | Command may slide |
| wr_valid | output | 1 | Register write strobe |
| wr_sel | output | 1 | 0 coefficient, 1 calibration |
| wr_data | output | 8 | Write data |
| done | output | 1 | Sequence finished pulse |
| err | output | 1 | Sequence failed pulse |

## Verification
The bench builds the block with its default parameters: a 38400 kHz reference, a 1300000 kHz VCO floor (NMIN = 34), a 614400 kHz safety threshold, a 76800 kHz margin and post dividers up to 31. With these values, frequencies of a few hundred MHz drive the safe divider below NMIN, so the post-divider search yields ratios 2 and 3, while a 1.6 GHz point keeps the base divider. The threshold can be probed at exactly 614400 and 614401 kHz. Every decision branch can therefore be reached with realistic operating points: bypass, rising voltage, falling voltage, low old frequency, bad divider, and failure of either command.

// File: rtl/dvfs_seq_pkg.sv
package dvfs_seq_pkg;

    localparam int FREQ_W = 22;
    localparam int NDIV_W = 8;
    localparam int PDIV_W = 6;
    localparam int MDIV_W = 6;
    localparam int MV_W   = 11;
    localparam int COEF_W = 7;
    localparam int CAL_W  = 8;
    localparam int WDAT_W = (COEF_W > CAL_W) ? COEF_W : CAL_W;

    localparam logic WSEL_COEF = 1'b0;
    localparam logic WSEL_CAL  = 1'b1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_SAFE,
        ST_WR_ZERO,
        ST_WR_CAL,
        ST_WR_COEF,
        ST_FINAL,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

    typedef struct packed {
        logic [FREQ_W-1:0] freq;
        logic [PDIV_W-1:0] pdiv;
        logic [MV_W-1:0]   mv;
    } old_pt_t;

    typedef struct packed {
        logic [FREQ_W-1:0] freq;
        logic [NDIV_W-1:0] ndiv;
        logic [PDIV_W-1:0] pdiv;
        logic [MV_W-1:0]   mv;
        logic [COEF_W-1:0] coef;
        logic [CAL_W-1:0]  cal;
    } new_pt_t;

    typedef struct packed {
        seq_state_e        st;
        old_pt_t           od;
        new_pt_t           nw;
        logic [MDIV_W-1:0] mdiv;
        logic              en;
        logic              slide_req;
        logic              fin_slide;
    } seq_regs_t;

endpackage

// File: rtl/dvfs_seq_route.sv
module dvfs_seq_route
    import dvfs_seq_pkg::*;
#(
    parameter int SAFE_MIN_KHZ = 614400
) (
    input  logic [FREQ_W-1:0] old_freq,
    input  logic [MV_W-1:0]   old_mv,
    input  logic [MV_W-1:0]   new_mv,
    input  logic [MDIV_W-1:0] new_mdiv,
    input  logic              new_en,
    input  logic              slide_ok,
    output logic              m_bad,
    output logic              bypass,
    output logic              need_safe,
    output logic              volt_up
);
    localparam logic [FREQ_W-1:0] SAFE_MIN_F = FREQ_W'(SAFE_MIN_KHZ);
    localparam logic [MDIV_W-1:0] ONE_M      = MDIV_W'(1);

    always_comb begin
        m_bad     = (new_mdiv != ONE_M);
        bypass    = !slide_ok || !new_en || (old_mv == new_mv);
        need_safe = (old_freq > SAFE_MIN_F);
        volt_up   = (old_mv < new_mv);
    end
endmodule

// File: rtl/dvfs_seq_safecfg.sv
module dvfs_seq_safecfg
    import dvfs_seq_pkg::*;
#(
    parameter int REF_KHZ         = 38400,
    parameter int VCO_MIN_KHZ     = 1300000,
    parameter int SAFE_MIN_KHZ    = 614400,
    parameter int SAFE_MARGIN_KHZ = 76800,
    parameter int PDIV_MAX        = 31
) (
    input  logic [FREQ_W-1:0] base_freq,
    input  logic [PDIV_W-1:0] base_pdiv,
    output logic [FREQ_W-1:0] safe_freq,
    output logic [NDIV_W-1:0] safe_ndiv,
    output logic [PDIV_W-1:0] safe_pdiv
);
    localparam int NMIN   = (VCO_MIN_KHZ + REF_KHZ - 1) / REF_KHZ;
    localparam int PROD_W = FREQ_W + PDIV_W;
    localparam logic [FREQ_W-1:0] SAFE_MIN_F = FREQ_W'(SAFE_MIN_KHZ);
    localparam logic [FREQ_W-1:0] MARGIN_F   = FREQ_W'(SAFE_MARGIN_KHZ);
    localparam logic [FREQ_W-1:0] REF_F      = FREQ_W'(REF_KHZ);
    localparam logic [FREQ_W-1:0] NMIN_F     = FREQ_W'(NMIN);
    localparam logic [PROD_W-1:0] FLOOR_P    = PROD_W'(NMIN * REF_KHZ);

    logic [FREQ_W-1:0] f_adj;
    logic [FREQ_W-1:0] n_raw;
    logic [PDIV_MAX:1] fits;

    assign f_adj = (base_freq > SAFE_MIN_F) ? (base_freq - MARGIN_F) : base_freq;
    assign n_raw = f_adj / REF_F;

    for (genvar d = 1; d <= PDIV_MAX; d++) begin : g_div
        assign fits[d] = (PROD_W'(d) * PROD_W'(f_adj)) >= FLOOR_P;
    end

    always_comb begin
        safe_freq = f_adj;
        safe_ndiv = NDIV_W'(n_raw);
        safe_pdiv = base_pdiv;
        if (n_raw < NMIN_F) begin
            safe_ndiv = NDIV_W'(NMIN);
            safe_pdiv = PDIV_W'(PDIV_MAX);
            for (int d = PDIV_MAX; d >= 1; d--) begin
                if (fits[d]) safe_pdiv = PDIV_W'(d);
            end
        end
    end
endmodule

// File: rtl/dvfs_pll_seq.sv
module dvfs_pll_seq
    import dvfs_seq_pkg::*;
#(
    parameter int REF_KHZ         = 38400,
    parameter int VCO_MIN_KHZ     = 1300000,
    parameter int SAFE_MIN_KHZ    = 614400,
    parameter int SAFE_MARGIN_KHZ = 76800,
    parameter int PDIV_MAX        = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_slide,
    input  logic [FREQ_W-1:0] old_freq,
    input  logic [PDIV_W-1:0] old_pdiv,
    input  logic [MV_W-1:0]   old_mv,
    input  logic [FREQ_W-1:0] new_freq,
    input  logic [MDIV_W-1:0] new_mdiv,
    input  logic [NDIV_W-1:0] new_ndiv,
    input  logic [PDIV_W-1:0] new_pdiv,
    input  logic [MV_W-1:0]   new_mv,
    input  logic [COEF_W-1:0] new_coef,
    input  logic [CAL_W-1:0]  new_cal,
    input  logic              new_en,
    output logic              cmd_valid,
    input  logic              cmd_ack,
    input  logic              cmd_fail,
    output logic [FREQ_W-1:0] cmd_freq,
    output logic [NDIV_W-1:0] cmd_ndiv,
    output logic [PDIV_W-1:0] cmd_pdiv,
    output logic [MV_W-1:0]   cmd_mv,
    output logic              cmd_en,
    output logic              cmd_slide,
    output logic              wr_valid,
    output logic              wr_sel,
    output logic [WDAT_W-1:0] wr_data,
    output logic              done,
    output logic              err
);
    seq_regs_t s_d, s_q;

    logic m_bad, bypass, need_safe, volt_up;
    logic [FREQ_W-1:0] safe_freq;
    logic [NDIV_W-1:0] safe_ndiv;
    logic [PDIV_W-1:0] safe_pdiv;
    logic [FREQ_W-1:0] base_freq;
    logic [PDIV_W-1:0] base_pdiv;
    logic [MV_W-1:0]   safe_mv;
    logic              in_safe;

    dvfs_seq_route #(.SAFE_MIN_KHZ(SAFE_MIN_KHZ)) route_i (
        .old_freq (s_q.od.freq),
        .old_mv   (s_q.od.mv),
        .new_mv   (s_q.nw.mv),
        .new_mdiv (s_q.mdiv),
        .new_en   (s_q.en),
        .slide_ok (s_q.slide_req),
        .m_bad    (m_bad),
        .bypass   (bypass),
        .need_safe(need_safe),
        .volt_up  (volt_up)
    );

    // rising voltage: old point as base; falling: new point as base
    assign base_freq = volt_up ? s_q.od.freq : s_q.nw.freq;
    assign base_pdiv = volt_up ? s_q.od.pdiv : s_q.nw.pdiv;
    assign safe_mv   = volt_up ? s_q.nw.mv   : s_q.od.mv;

    dvfs_seq_safecfg #(
        .REF_KHZ        (REF_KHZ),
        .VCO_MIN_KHZ    (VCO_MIN_KHZ),
        .SAFE_MIN_KHZ   (SAFE_MIN_KHZ),
        .SAFE_MARGIN_KHZ(SAFE_MARGIN_KHZ),
        .PDIV_MAX       (PDIV_MAX)
    ) safe_i (
        .base_freq(base_freq),
        .base_pdiv(base_pdiv),
        .safe_freq(safe_freq),
        .safe_ndiv(safe_ndiv),
        .safe_pdiv(safe_pdiv)
    );

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st        = ST_DECIDE;
                    s_d.od        = '{freq: old_freq, pdiv: old_pdiv, mv: old_mv};
                    s_d.nw        = '{freq: new_freq, ndiv: new_ndiv, pdiv: new_pdiv,
                                      mv: new_mv, coef: new_coef, cal: new_cal};
                    s_d.mdiv      = new_mdiv;
                    s_d.en        = new_en;
                    s_d.slide_req = req_slide;
                end
            end
            ST_DECIDE: begin
                if (m_bad) begin
                    s_d.st = ST_FAIL;
                end else if (bypass) begin
                    s_d.st        = ST_FINAL;
                    s_d.fin_slide = s_q.slide_req;
                end else begin
                    s_d.fin_slide = 1'b1;
                    s_d.st        = need_safe ? ST_SAFE : ST_WR_ZERO;
                end
            end
            ST_SAFE:    if (cmd_ack) s_d.st = cmd_fail ? ST_FAIL : ST_WR_ZERO;
            ST_WR_ZERO: s_d.st = ST_WR_CAL;
            ST_WR_CAL:  s_d.st = ST_WR_COEF;
            ST_WR_COEF: s_d.st = ST_FINAL;
            ST_FINAL:   if (cmd_ack) s_d.st = cmd_fail ? ST_FAIL : ST_DONE;
            default:    s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_safe   = (s_q.st == ST_SAFE);
    assign req_ready = (s_q.st == ST_IDLE);
    assign cmd_valid = in_safe || (s_q.st == ST_FINAL);
    assign cmd_freq  = in_safe ? safe_freq : s_q.nw.freq;
    assign cmd_ndiv  = in_safe ? safe_ndiv : s_q.nw.ndiv;
    assign cmd_pdiv  = in_safe ? safe_pdiv : s_q.nw.pdiv;
    assign cmd_mv    = in_safe ? safe_mv   : s_q.nw.mv;
    assign cmd_en    = in_safe ? 1'b1      : s_q.en;
    assign cmd_slide = in_safe ? 1'b1      : s_q.fin_slide;
    assign wr_valid  = (s_q.st == ST_WR_ZERO) || (s_q.st == ST_WR_CAL) || (s_q.st == ST_WR_COEF);
    assign wr_sel    = (s_q.st == ST_WR_CAL) ? WSEL_CAL : WSEL_COEF;
    assign wr_data   = (s_q.st == ST_WR_CAL)  ? WDAT_W'(s_q.nw.cal)  :
                       (s_q.st == ST_WR_COEF) ? WDAT_W'(s_q.nw.coef) : '0;
    assign done      = (s_q.st == ST_DONE);
    assign err       = (s_q.st == ST_FAIL);

    // R10
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_freq) && $stable(cmd_ndiv)
                                 && $stable(cmd_pdiv) && $stable(cmd_mv) && $stable(cmd_slide));

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R8
    wr_first_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> (wr_sel == WSEL_COEF) && (wr_data == '0));

    // R8
    wr_cal_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && (wr_sel == WSEL_CAL) |-> $past(wr_valid) && ($past(wr_sel) == WSEL_COEF)
                                            && ($past(wr_data) == '0));

    // R7
    fail_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ack && cmd_fail |=> err && !wr_valid && !cmd_valid);

    // R9
    outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err, cmd_valid, wr_valid}));
endmodule

// File: tb/dvfs_pll_seq_tb.sv
module dvfs_pll_seq_tb_top;
    import dvfs_seq_pkg::*;

    localparam int ACK_DLY = 2;
    localparam int MAXEV   = 8;

    typedef struct packed {
        int ofreq; int opdiv; int omv;
        int nfreq; int nmdiv; int nndiv; int npdiv; int nmv;
        int ncoef; int ncal;  int nen;   int slide; int fail_at;
    } vec_t;

    localparam int NV = 13;
    // ofreq, opdiv, omv, nfreq, nmdiv, nndiv, npdiv, nmv, ncoef, ncal, nen, slide, fail_at
    localparam vec_t VECS [NV] = '{
        '{800000, 1,  900, 1000000, 1, 26, 1, 1000, 30, 40, 1, 0, 0},
        '{800000, 1,  900, 1000000, 1, 26, 1, 1000, 30, 40, 0, 1, 0},
        '{800000, 1,  900, 1000000, 1, 26, 1,  900, 30, 40, 1, 1, 0},
        '{800000, 1,  900, 1000000, 1, 26, 1, 1000, 30, 40, 1, 1, 0},
        '{1600000, 1, 1100, 1400000, 1, 36, 1, 1000, 12, 55, 1, 1, 0},
        '{1600000, 1,  900, 1900000, 1, 49, 1, 1050,  5, 77, 1, 1, 0},
        '{614400, 2,  900, 1000000, 1, 26, 1, 1000, 30, 40, 1, 1, 0},
        '{614401, 1, 1000,  500000, 1, 13, 2,  900,  3,  9, 1, 1, 0},
        '{800000, 1,  900, 1000000, 2, 26, 1, 1000, 30, 40, 1, 1, 0},
        '{800000, 1,  900, 1000000, 1, 26, 1, 1000, 30, 40, 1, 1, 1},
        '{800000, 1,  900, 1000000, 1, 26, 1, 1000, 30, 40, 1, 1, 2},
        '{800000, 1,  900, 1000000, 1, 26, 1, 1000, 30, 40, 1, 0, 1},
        '{300000, 1,  800,  700000, 1, 18, 1,  950,  0,  3, 1, 1, 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_slide = 1'b0, new_en = 1'b0;
    logic [FREQ_W-1:0] old_freq = '0, new_freq = '0;
    logic [PDIV_W-1:0] old_pdiv = '0, new_pdiv = '0;
    logic [MV_W-1:0]   old_mv = '0, new_mv = '0;
    logic [MDIV_W-1:0] new_mdiv = '0;
    logic [NDIV_W-1:0] new_ndiv = '0;
    logic [COEF_W-1:0] new_coef = '0;
    logic [CAL_W-1:0]  new_cal = '0;
    logic cmd_ack = 1'b0, cmd_fail = 1'b0;
    logic req_ready, cmd_valid, cmd_en, cmd_slide, wr_valid, wr_sel, done, err;
    logic [FREQ_W-1:0] cmd_freq;
    logic [NDIV_W-1:0] cmd_ndiv;
    logic [PDIV_W-1:0] cmd_pdiv;
    logic [MV_W-1:0]   cmd_mv;
    logic [WDAT_W-1:0] wr_data;

    always #5 clk = ~clk;

    dvfs_pll_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_slide(req_slide), .old_freq(old_freq), .old_pdiv(old_pdiv), .old_mv(old_mv),
        .new_freq(new_freq), .new_mdiv(new_mdiv), .new_ndiv(new_ndiv), .new_pdiv(new_pdiv),
        .new_mv(new_mv), .new_coef(new_coef), .new_cal(new_cal), .new_en(new_en),
        .cmd_valid(cmd_valid), .cmd_ack(cmd_ack), .cmd_fail(cmd_fail), .cmd_freq(cmd_freq),
        .cmd_ndiv(cmd_ndiv), .cmd_pdiv(cmd_pdiv), .cmd_mv(cmd_mv), .cmd_en(cmd_en),
        .cmd_slide(cmd_slide), .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
        .done(done), .err(err)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // event log: kind 0 command, 1 coefficient write, 2 calibration write
    int lg_n = 0, lg_k[MAXEV], lg_a[MAXEV], lg_b[MAXEV], lg_c[MAXEV], lg_d[MAXEV], lg_e[MAXEV];
    int ex_n = 0, ex_k[MAXEV], ex_a[MAXEV], ex_b[MAXEV], ex_c[MAXEV], ex_d[MAXEV], ex_e[MAXEV];
    int fail_at = 0, cmd_seen = 0, wait_cnt = 0;
    int h_freq = 0, h_mv = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // downstream agent and write logger
    initial forever begin
        @(negedge clk);
        cmd_ack  = 1'b0;
        cmd_fail = 1'b0;
        if (wr_valid && lg_n < MAXEV) begin
            lg_k[lg_n] = (wr_sel == WSEL_CAL) ? 2 : 1;
            lg_a[lg_n] = int'(wr_data);
            lg_b[lg_n] = 0; lg_c[lg_n] = 0; lg_d[lg_n] = 0; lg_e[lg_n] = 0;
            lg_n++;
        end
        if (cmd_valid) begin
            if (wait_cnt == 0) begin
                h_freq = int'(cmd_freq);
                h_mv   = int'(cmd_mv);
            end
            if (wait_cnt < ACK_DLY) begin
                wait_cnt++;
            end else begin
                // R10 payload held while waiting for acknowledge
                check(h_freq == int'(cmd_freq) && h_mv == int'(cmd_mv), "R10 hold",
                      int'(cmd_freq), h_freq);
                if (lg_n < MAXEV) begin
                    lg_k[lg_n] = 0; lg_a[lg_n] = int'(cmd_freq); lg_b[lg_n] = int'(cmd_ndiv);
                    lg_c[lg_n] = int'(cmd_pdiv); lg_d[lg_n] = int'(cmd_mv);
                    lg_e[lg_n] = int'(cmd_en) * 2 + int'(cmd_slide);
                    lg_n++;
                end
                cmd_seen++;
                cmd_ack  = 1'b1;
                cmd_fail = (cmd_seen == fail_at);
                wait_cnt = 0;
            end
        end
    end

    task automatic push(input int k, input int a, input int b, input int c, input int d, input int e);
        ex_k[ex_n] = k; ex_a[ex_n] = a; ex_b[ex_n] = b;
        ex_c[ex_n] = c; ex_d[ex_n] = d; ex_e[ex_n] = e;
        ex_n++;
    endtask

    // expected outcome: 0 done, 1 error
    task automatic build_expect(input vec_t v, output int exp_err, output string tag);
        int base_f, base_p, f, n, p, smv, ncmd;
        bit up;
        ex_n = 0;
        exp_err = 0;
        up = v.omv < v.nmv;
        if (v.nmdiv != 1) begin
            exp_err = 1; tag = "R1";
        end else if (v.slide == 0 || v.nen == 0 || v.omv == v.nmv) begin
            tag = "R2";
            push(0, v.nfreq, v.nndiv, v.npdiv, v.nmv, v.nen * 2 + v.slide);
            exp_err = (v.fail_at == 1) ? 1 : 0;
        end else begin
            tag = up ? "R4" : "R5";
            ncmd = 0;
            if (v.ofreq > 614400) begin
                base_f = up ? v.ofreq : v.nfreq;
                base_p = up ? v.opdiv : v.npdiv;
                smv    = up ? v.nmv : v.omv;
                f = (base_f > 614400) ? base_f - 76800 : base_f;
                n = f / 38400;
                p = base_p;
                if (n < 34) begin
                    n = 34; p = 1;
                    while (p < 31 && p * f < 34 * 38400) p++;
                end
                push(0, f, n, p, smv, 3);
                ncmd = 1;
                if (v.fail_at == 1) begin
                    exp_err = 1; tag = "R7";
                end
            end
            if (exp_err == 0) begin
                push(1, 0, 0, 0, 0, 0);
                push(2, v.ncal, 0, 0, 0, 0);
                push(1, v.ncoef, 0, 0, 0, 0);
                push(0, v.nfreq, v.nndiv, v.npdiv, v.nmv, 3);
                if (v.fail_at == ncmd + 1) begin
                    exp_err = 1; tag = "R11";
                end
            end
        end
    endtask

    task automatic run_vec(input vec_t v, input bit poke_busy);
        int exp_err, got_err, cyc;
        string tag;
        old_freq = FREQ_W'(v.ofreq); old_pdiv = PDIV_W'(v.opdiv); old_mv = MV_W'(v.omv);
        new_freq = FREQ_W'(v.nfreq); new_mdiv = MDIV_W'(v.nmdiv); new_ndiv = NDIV_W'(v.nndiv);
        new_pdiv = PDIV_W'(v.npdiv); new_mv = MV_W'(v.nmv); new_coef = COEF_W'(v.ncoef);
        new_cal = CAL_W'(v.ncal); new_en = v.nen[0]; req_slide = v.slide[0];
        fail_at = v.fail_at; cmd_seen = 0; lg_n = 0; wait_cnt = 0;
        cyc = 0;
        while (!req_ready && cyc < 50) begin @(negedge clk); cyc++; end
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = poke_busy;
        if (poke_busy) begin
            // R10 a busy-time request with other data must be ignored
            new_freq = FREQ_W'(123456); new_mv = MV_W'(700);
        end
        cyc = 0;
        while (!done && !err && cyc < 200) begin @(negedge clk); cyc++; end
        got_err = err ? 1 : 0;
        req_valid = 1'b0;
        build_expect(v, exp_err, tag);
        check(done || err, tag, got_err, exp_err);
        check(got_err == exp_err, tag, got_err, exp_err);
        check(lg_n == ex_n, "R3", lg_n, ex_n);
        for (int i = 0; i < ex_n && i < lg_n; i++) begin
            string etag;
            etag = (ex_k[i] != 0) ? "R8" : (i == ex_n - 1) ? "R9" : "R6";
            check(lg_k[i] == ex_k[i], etag, lg_k[i], ex_k[i]);
            check(lg_a[i] == ex_a[i], etag, lg_a[i], ex_a[i]);
            check(lg_b[i] == ex_b[i] && lg_c[i] == ex_c[i], etag, lg_c[i], ex_c[i]);
            check(lg_d[i] == ex_d[i], etag, lg_d[i], ex_d[i]);
            check(lg_e[i] == ex_e[i], etag, lg_e[i], ex_e[i]);
        end
        @(negedge clk);
        check(req_ready == 1'b1 && !done && !err, "R10", int'(req_ready), 1);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        check(req_ready && !cmd_valid && !wr_valid && !done && !err, "R10", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);
        // R10 busy-time request ignored while rising-voltage sequence runs
        run_vec(VECS[3], 1'b1);
        check(!cmd_valid && !wr_valid && req_ready, "R10", int'(cmd_valid), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule